// File: doc/BRIEF.md
# Gated Clock Fanout Controller

The block picks one of two clock sources, a fast system clock or a slower scan/test clock, and copies the picked clock onto a set of output channels. Each channel can be switched off. A shared active-low enable switches off every channel at once. A per-channel active-low enable switches off one channel.

Enable requests are captured on the falling edge of the picked clock. A channel therefore starts or stops only while the clock is low. Every high pulse it emits has the full width of the source's high phase, and no pulse is cut short. A switched-off channel holds its clock output low and raises an off flag, which stands in for a high-impedance output. An asynchronous reset puts every channel into the off state. It is needed because the captured enables have no defined value at power-up.

Switching the source select is not glitch-free. It is meant for quiescent reconfiguration only.

Top module: `clk_fanout_gate`

## Requirements
- R1: With `src_sel` = 0, enabled outputs follow `sys_clk`. With `src_sel` = 1, they follow `tst_clk`.
- R2: Channel i is enabled exactly when `cen_n` = 0 and `en_n[i]` = 0, both active low. Bit i of `en_n`, `clk_out` and `chan_off` belongs to channel i.
- R3: `cen_n` and `en_n` are sampled on the falling edge of the selected clock. The sampled state governs the outputs from the next rising edge onward.
- R4: A change on `cen_n` or `en_n` during a high phase of the selected clock leaves `clk_out` and `chan_off` unchanged until the next falling edge.
- R5: A disabled channel drives `clk_out[i]` = 0 and `chan_off[i]` = 1. An enabled channel drives `chan_off[i]` = 0. During the low phase every `clk_out` bit is 0.
- R6: `cen_n` = 1, once sampled, disables all channels whatever the value of `en_n`.
- R7: `en_n[i]` = 1, once sampled, disables channel i only. The other channels keep their state.
- R8: `rst_n` = 0 disables all channels at once, without waiting for a clock edge.
- R9: Every high pulse on any `clk_out` bit lasts exactly one high phase of the selected clock, even when the enables toggle at arbitrary times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Fast system clock source |
| tst_clk | input | 1 | Slow scan/test clock source |
| src_sel | input | 1 | Source select: 0 system, 1 test |
| rst_n | input | 1 | Asynchronous active-low reset, disables all channels |
| cen_n | input | 1 | Common active-low enable |
| en_n | input | NCH | Per-channel active-low enables |
| clk_out | output | NCH | Gated clock outputs |
| chan_off | output | NCH | Per-channel disabled flag, high-impedance stand-in |

## Verification
The bench builds the block with the default of six channels. This keeps the common enable and the six per-channel enables at 128 combinations, so all of them are swept on each clock source. The system clock runs at 8 ns and the test clock at 40 ns. With those periods, stimulus can be placed deliberately inside a high phase, where it must have no effect. The stimulus is also placed at random instants, while every output pulse width is measured against the selected source's high phase.

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate #(
  parameter int NCH = 6
) (
  input  logic           sys_clk,
  input  logic           tst_clk,
  input  logic           src_sel,
  input  logic           rst_n,
  input  logic           cen_n,
  input  logic [NCH-1:0] en_n,
  output logic [NCH-1:0] clk_out,
  output logic [NCH-1:0] chan_off
);

  logic           sel_clk;
  logic [NCH-1:0] gate_q;

  assign sel_clk = src_sel ? tst_clk : sys_clk;

  always_ff @(negedge sel_clk or negedge rst_n)
    if (!rst_n) gate_q <= '0;
    else        gate_q <= ~en_n & {NCH{~cen_n}};

  assign clk_out  = {NCH{sel_clk}} & gate_q;
  assign chan_off = ~gate_q;

  p_common_off_r6: assert property (@(negedge sel_clk) disable iff (!rst_n)
    cen_n |=> &chan_off);

  p_reset_off_r8: assert property (@(posedge sys_clk)
    !rst_n |-> (&chan_off && clk_out == '0));

  always @(chan_off)
    if (rst_n === 1'b1)
      p_low_phase_change_r4: assert (sel_clk == 1'b0);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_single_off_r7: assert property (@(negedge sel_clk) disable iff (!rst_n)
      en_n[i] |=> chan_off[i]);
    p_enable_on_r2: assert property (@(negedge sel_clk) disable iff (!rst_n)
      (!cen_n && !en_n[i]) |=> !chan_off[i]);
  end

endmodule

// File: tb/clk_fanout_gate_tb.sv
`timescale 1ns/1ps
module clk_fanout_gate_tb;
  localparam int NCH = 6;

  logic sys_clk = 1'b0;
  logic tst_clk = 1'b0;
  logic src_sel = 1'b0;
  logic rst_n   = 1'b0;
  logic cen_n   = 1'b1;
  logic [NCH-1:0] en_n = '1;
  logic [NCH-1:0] clk_out, chan_off;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  always #4  sys_clk = ~sys_clk;
  always #20 tst_clk = ~tst_clk;

  clk_fanout_gate #(.NCH(NCH)) u_dut (
    .sys_clk(sys_clk), .tst_clk(tst_clk), .src_sel(src_sel), .rst_n(rst_n),
    .cen_n(cen_n), .en_n(en_n), .clk_out(clk_out), .chan_off(chan_off)
  );

  wire bclk = src_sel ? tst_clk : sys_clk;

  task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  for (genvar i = 0; i < NCH; i++) begin : g_mon
    realtime t_rise = 0.0;
    always @(posedge clk_out[i]) t_rise = $realtime;
    always @(negedge clk_out[i]) if (mon_en && rst_n) begin
      realtime w, e;
      w = $realtime - t_rise;
      e = src_sel ? 20.0 : 4.0;
      checks++;
      if (w != e) begin
        errors++;
        $display("FAIL R9 ch %0d: width %0.1f expected %0.1f", i, w, e);
      end
    end
  end

  task automatic sweep(input logic src);
    logic [NCH-1:0] prev;
    logic [NCH-1:0] mask;
    src_sel = src;
    repeat (3) @(posedge bclk);
    #1;
    prev = ~chan_off;
    for (int c = 0; c < 2*(1<<NCH); c++) begin
      @(posedge bclk); #1;
      cen_n = c[NCH];
      en_n  = c[NCH-1:0];
      mask  = cen_n ? '0 : ~en_n;
      #1;
      chk("R4 high-phase change ignored (off)", chan_off, ~prev);
      chk("R4 high-phase change ignored (out)", clk_out, prev);
      @(negedge bclk);
      @(posedge bclk); #1;
      chk(src ? "R1 R3 R6 R7 test clock out" : "R1 R3 R6 R7 system clock out", clk_out, mask);
      chk("R2 R5 off flag", chan_off, ~mask);
      @(negedge bclk); #1;
      chk("R5 low phase parks low", clk_out, '0);
      prev = mask;
    end
  endtask

  task automatic rand_run(input logic src);
    mon_en = 1'b0;
    src_sel = src;
    repeat (4) @(posedge bclk);
    mon_en = 1'b1;
    for (int k = 0; k < 300; k++) begin
      repeat ($urandom_range(1, 5)) @(posedge sys_clk);
      #1;
      cen_n = ($urandom_range(0, 7) == 0);
      en_n  = NCH'($urandom);
    end
    @(negedge bclk);
    #1;
    mon_en = 1'b0;
  endtask

  initial begin
    #3;
    chk("R8 reset state off", chan_off, '1);
    chk("R8 reset state out", clk_out, '0);
    cen_n = 1'b0; en_n = '0;
    repeat (2) @(posedge sys_clk); #1;
    chk("R8 reset holds off with enables low", chan_off, '1);
    @(negedge sys_clk); #1;
    rst_n = 1'b1;
    @(negedge sys_clk); @(posedge sys_clk); #1;
    chk("R2 all enabled after reset release", clk_out, '1);
    sweep(1'b0);
    sweep(1'b1);
    rand_run(1'b0);
    rand_run(1'b1);
    src_sel = 1'b0;
    cen_n = 1'b0; en_n = '0;
    repeat (3) @(posedge sys_clk);
    @(negedge sys_clk); #1;
    rst_n = 1'b0; #1;
    chk("R8 async reset off", chan_off, '1);
    @(posedge sys_clk); #1;
    chk("R8 async reset out low", clk_out, '0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule